// File: doc/BRIEF.md
# Privileged Control Register File

This block keeps two control registers for a processor core: an execution-mode register and a privilege-mask register. Software writes them through a strobe, a select and a data word. Each write is checked before it takes effect. A write that breaks a rule leaves the target register as it was. It also raises a fault pulse that lasts one cycle and carries a 3-bit exception code, which the core's exception logic then dispatches.

The mode register must always hold exactly one set bit. The pattern 100b selects 32-bit operation. A new mode applies from the next cycle, so no jump is needed after the write. The privilege register comes out of reset with every bit set. Direct writes can only remove privileges. Privileges are added only through a separate grant port, which handler-entry logic drives with a mask it has already computed. When a grant and a direct write arrive in the same cycle, the grant wins and the write is dropped without a fault.

Top module: `priv_ctrl_regs`

## Requirements
- R1: After reset, mode_o equals 100b (bit 2 set, all other bits clear) and priv_o has every bit set; fault_vld_o is low.
- R2: A write with wr_sel_i=0 whose data has exactly one bit set loads mode_o on the next clock edge and raises no fault.
- R3: A write with wr_sel_i=0 whose data has zero bits or more than one bit set leaves mode_o unchanged and, one cycle after the write, pulses fault_vld_o for one cycle with fault_code_o=2.
- R4: A write with wr_sel_i=1 whose data sets no bit that is clear in the current priv_o (data & ~priv_o == 0) loads priv_o on the next edge and raises no fault.
- R5: A write with wr_sel_i=1 whose data sets any currently clear bit leaves priv_o unchanged and, one cycle after the write, pulses fault_vld_o for one cycle with fault_code_o=3.
- R6: When grant_i is high, priv_o becomes priv_o | grant_mask_i on the next edge, and mode_o is not changed.
- R7: When grant_i and wr_en_i are high in the same cycle, the direct write is ignored: neither register takes its data, and no fault is raised.
- R8: fault_vld_o is high for one cycle at most per write, and fault_code_o is 0 whenever fault_vld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 1 | 0 = mode register, 1 = privilege register |
| wr_data_i | input | W | Write data |
| grant_i | input | 1 | Handler-entry privilege grant strobe |
| grant_mask_i | input | W | Privileges to add on grant |
| mode_o | output | W | Current mode register |
| priv_o | output | W | Current privilege register |
| fault_vld_o | output | 1 | One-cycle fault pulse |
| fault_code_o | output | 3 | Exception code (2 invalid op, 3 access violation) |

## Verification
Both registers drive the outputs directly, so a wrong internal value shows at the ports one cycle after the edge that caused it. With the default width of 4, the bench sweeps every write value against every reachable privilege value and every mode value. It also sweeps grant masks with and without a write in the same cycle. A wrong accept-or-reject decision therefore shows up as a register value that should not have changed, or as a missing or extra fault pulse one cycle after the write.

// File: rtl/priv_ctrl_regs.sv
module priv_ctrl_regs #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         grant_i,
  input  logic [W-1:0] grant_mask_i,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] priv_o,
  output logic         fault_vld_o,
  output logic [2:0]   fault_code_o
);
  localparam logic [W-1:0] MODE_RST = W'(4);
  localparam logic [2:0]   CODE_INVOP = 3'd2;
  localparam logic [2:0]   CODE_ACCV  = 3'd3;

  logic [W-1:0] mode_q, priv_q;
  logic         wr_live, mode_ok, priv_ok, mode_bad, priv_bad;

  assign wr_live  = wr_en_i && !grant_i;
  assign mode_ok  = $onehot(wr_data_i);
  assign priv_ok  = (wr_data_i & ~priv_q) == '0;
  assign mode_bad = wr_live && !wr_sel_i && !mode_ok;
  assign priv_bad = wr_live &&  wr_sel_i && !priv_ok;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q       <= MODE_RST;
      priv_q       <= '1;
      fault_vld_o  <= 1'b0;
      fault_code_o <= '0;
    end else begin
      if (grant_i)
        priv_q <= priv_q | grant_mask_i;
      else if (wr_live && wr_sel_i && priv_ok)
        priv_q <= wr_data_i;
      if (wr_live && !wr_sel_i && mode_ok)
        mode_q <= wr_data_i;
      fault_vld_o  <= mode_bad || priv_bad;
      fault_code_o <= mode_bad ? CODE_INVOP : (priv_bad ? CODE_ACCV : 3'd0);
    end
  end

  assign mode_o = mode_q;
  assign priv_o = priv_q;

  // R2
  mode_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(mode_o));
  // R3
  mode_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !grant_i && !wr_sel_i && !$onehot(wr_data_i))
      |=> ($stable(mode_o) && fault_vld_o && fault_code_o == 3'd2));
  // R5
  priv_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !grant_i && wr_sel_i && ((wr_data_i & ~priv_o) != '0))
      |=> ($stable(priv_o) && fault_vld_o && fault_code_o == 3'd3));
  // R4
  priv_no_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_i |=> ((priv_o & ~$past(priv_o)) == '0));
  // R7
  grant_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> (!fault_vld_o && $stable(mode_o)));
  // R8
  code_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_vld_o |-> fault_code_o == 3'd0);
endmodule

// File: tb/priv_ctrl_regs_tb_top.sv
module priv_ctrl_regs_tb_top;
  localparam int W = 4;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, grant = 0;
  logic [W-1:0] wr_data = '0, gmask = '0;
  logic [W-1:0] mode, priv;
  logic fvld;
  logic [2:0] fcode;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  priv_ctrl_regs #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .grant_i(grant), .grant_mask_i(gmask),
    .mode_o(mode), .priv_o(priv), .fault_vld_o(fvld), .fault_code_o(fcode));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, one cycle, then sample at next negedge
  task automatic step(input logic en, input logic sel, input logic [W-1:0] d,
                      input logic g, input logic [W-1:0] m);
    wr_en = en; wr_sel = sel; wr_data = d; grant = g; gmask = m;
    @(negedge clk);
    wr_en = 0; grant = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic set_priv(input logic [W-1:0] p);
    do_reset();
    step(1, 1, p, 0, '0);
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 mode", 8'(mode), 8'h4);
    chk("R1 priv", 8'(priv), 8'hF);
    chk("R1 fault", 8'(fvld), 8'h0);

    // R2/R3: all mode write values from each legal mode
    for (int s = 0; s < W; s++) begin
      for (int d = 0; d < (1 << W); d++) begin
        logic [W-1:0] start, dv, expm;
        logic good;
        start = W'(1 << s);
        dv = W'(d);
        step(1, 0, start, 0, '0);
        good = $countones(dv) == 1;
        expm = good ? dv : start;
        step(1, 0, dv, 0, '0);
        chk(good ? "R2 mode" : "R3 mode", 8'(mode), 8'(expm));
        chk("R8 vld", 8'(fvld), good ? 8'h0 : 8'h1);
        chk("R8 code", 8'(fcode), good ? 8'h0 : 8'h2);
        chk("R3 priv", 8'(priv), 8'hF);
        step(0, 0, '0, 0, '0);
        chk("R8 one-cycle", 8'(fvld), 8'h0);
      end
    end

    // R4/R5: every write against every privilege value
    for (int p = 0; p < (1 << W); p++) begin
      for (int d = 0; d < (1 << W); d++) begin
        logic [W-1:0] pv, dv;
        logic good;
        pv = W'(p); dv = W'(d);
        set_priv(pv);
        good = (dv & ~pv) == '0;
        step(1, 1, dv, 0, '0);
        chk(good ? "R4 priv" : "R5 priv", 8'(priv), good ? 8'(dv) : 8'(pv));
        chk("R5 vld", 8'(fvld), good ? 8'h0 : 8'h1);
        chk("R5 code", 8'(fcode), good ? 8'h0 : 8'h3);
        chk("R5 mode", 8'(mode), 8'h4);
      end
    end

    // R6/R7: grants alone and with a colliding write
    for (int p = 0; p < (1 << W); p++) begin
      for (int m = 0; m < (1 << W); m++) begin
        logic [W-1:0] pv, mv;
        pv = W'(p); mv = W'(m);
        set_priv(pv);
        step(0, 0, '0, 1, mv);
        chk("R6 priv", 8'(priv), 8'(pv | mv));
        chk("R6 mode", 8'(mode), 8'h4);
        set_priv(pv);
        step(1, 1, 4'hF, 1, mv);
        chk("R7 priv", 8'(priv), 8'(pv | mv));
        chk("R7 fault", 8'(fvld), 8'h0);
        step(1, 0, 4'h3, 1, mv);
        chk("R7 mode", 8'(mode), 8'h4);
        chk("R7 modefault", 8'(fvld), 8'h0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule